// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block produces memory addresses for a signal-processing datapath, so that address arithmetic runs beside the arithmetic on data. It holds a small file of address pointers. Each pointer has its own window base, window length and stepping mode. When an update strobe arrives, the selected pointer moves by one step in its own mode. The modes are a plain increment, a circular increment, a circular decrement, and a bit-reversed increment.

The circular modes turn a region of memory into a ring. Each new sample is written over the oldest entry, so the window of held samples slides forward by one per sample. The read pointer wraps around inside the same region. The bit-reversed mode walks a power-of-two table in the scrambled order that an in-place FFT needs. A pointer can also be loaded directly. The address of the selected pointer appears on the output without a register stage.

Top module: `agu_top`

## Requirements
- R1: After reset, every pointer holds address 0 in mode 0 (linear), with base 0 and length 1.
- R2: `addr_o` shows, combinationally, the address of the pointer chosen by `sel`.
- R3: With `ld_en` high, the selected pointer takes the value `ld_val` at the clock edge.
- R4: When `ld_en` and `upd` are both high in one cycle, the load wins and the step is discarded.
- R5: Mode 0 (linear): on `upd`, the address becomes address+1, wrapping from 0xFFFF to 0x0000.
- R6: Mode 1 (circular up): on `upd`, if address−base equals n−1 (or is larger), the address returns to base. Otherwise it becomes address+1. n may be any value of 1 or more.
- R7: Mode 2 (circular down): on `upd`, if the address equals base, it becomes base+n−1. Otherwise it becomes address−1.
- R8: Mode 3 (bit-reversed): n is a power of two. On `upd`, 1 is added at bit log2(n)−1 of the offset address−base, and the carry travels toward bit 0. For n=8 the offsets run 0,4,2,6,1,5,3,7,0.
- R9: `cfg_we` writes `cfg_mode`, `cfg_base` and `cfg_len` into the selected pointer's settings, and its address stays unchanged. A step in the same cycle uses the old settings.
- R10: Only the selected pointer can change. With no `ld_en` and no `upd`, the selected address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Pointer select |
| cfg_we | input | 1 | Write mode, base and length of the selected pointer |
| cfg_mode | input | 2 | Step mode: 0 linear, 1 circular up, 2 circular down, 3 bit-reversed |
| cfg_base | input | 16 | Window base |
| cfg_len | input | 16 | Window length n |
| ld_en | input | 1 | Load the selected pointer |
| ld_val | input | 16 | Load value |
| upd | input | 1 | Step the selected pointer |
| addr_o | output | 16 | Address of the selected pointer |

## Verification
The bench drives the circular-up mode through its wrap point with a length that is not a power of two. A design that compared the offset against n instead of n−1 would reach base+n before it wrapped. It drives the circular-down mode across the base, where a design with the wrong wrap would fall below the window. It also walks a full bit-reversed cycle of eight entries, where a carry sent the wrong way would produce the linear order. The remaining checks cover three cases: a load and a step in the same cycle, where the wrong priority leaves the address one step away from the loaded value; the linear wrap at 0xFFFF; and neighbour pointers that stay unchanged while another pointer steps.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AW   = 16;
    localparam int NREG = 4;
    localparam int SELW = $clog2(NREG);

    typedef enum logic [1:0] {
        MODE_LIN  = 2'd0,
        MODE_MINC = 2'd1,
        MODE_MDEC = 2'd2,
        MODE_BREV = 2'd3
    } step_mode_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] base;
        logic [AW-1:0] len;
        step_mode_e    mode;
    } ptr_ent_t;
endpackage

// File: rtl/agu_brev_inc.sv
module agu_brev_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] mask;
    logic         carry;

    assign mask = len_i - 1'b1;

    always_comb begin
        nxt_o = off_i;
        carry = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i] && carry) begin
                carry    = off_i[i];
                nxt_o[i] = ~off_i[i];
            end
        end
    end
endmodule

// File: rtl/agu_step.sv
module agu_step
    import agu_pkg::*;
#(
    parameter int W = AW
) (
    input  step_mode_e   mode_i,
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] off;
    logic [W-1:0] last_off;
    logic [W-1:0] brev_off;

    assign off      = addr_i - base_i;
    assign last_off = len_i - 1'b1;

    agu_brev_inc #(.W(W)) u_brev (
        .off_i (off),
        .len_i (len_i),
        .nxt_o (brev_off)
    );

    always_comb begin
        unique case (mode_i)
            MODE_LIN:  nxt_o = addr_i + 1'b1;
            MODE_MINC: nxt_o = (off >= last_off) ? base_i : addr_i + 1'b1;
            MODE_MDEC: nxt_o = (addr_i == base_i) ? base_i + last_off : addr_i - 1'b1;
            MODE_BREV: nxt_o = base_i + brev_off;
            default:   nxt_o = addr_i;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [AW-1:0]   cfg_base,
    input  logic [AW-1:0]   cfg_len,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_val,
    input  logic            upd,
    output logic [AW-1:0]   addr_o
);
    typedef struct packed {
        ptr_ent_t [NREG-1:0] ent;
    } agu_state_t;

    agu_state_t    s_d, s_q;
    logic [AW-1:0] step_nxt [NREG];
    step_mode_e    sel_mode;
    logic [AW-1:0] sel_base;
    logic [AW-1:0] sel_len;

    for (genvar g = 0; g < NREG; g++) begin : g_step
        agu_step #(.W(AW)) u_step (
            .mode_i (s_q.ent[g].mode),
            .addr_i (s_q.ent[g].addr),
            .base_i (s_q.ent[g].base),
            .len_i  (s_q.ent[g].len),
            .nxt_o  (step_nxt[g])
        );
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SELW'(i)) begin
                if (cfg_we) begin
                    s_d.ent[i].mode = step_mode_e'(cfg_mode);
                    s_d.ent[i].base = cfg_base;
                    s_d.ent[i].len  = cfg_len;
                end
                if (ld_en) begin
                    s_d.ent[i].addr = ld_val;
                end else if (upd) begin
                    s_d.ent[i].addr = step_nxt[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                s_q.ent[i].addr <= '0;
                s_q.ent[i].base <= '0;
                s_q.ent[i].len  <= AW'(1);
                s_q.ent[i].mode <= MODE_LIN;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o   = s_q.ent[sel].addr;
    assign sel_mode = s_q.ent[sel].mode;
    assign sel_base = s_q.ent[sel].base;
    assign sel_len  = s_q.ent[sel].len;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [SELW-1:0] sel,
    input logic            cfg_we,
    input logic            ld_en,
    input logic [AW-1:0]   ld_val,
    input logic            upd,
    input logic [AW-1:0]   addr_o,
    input step_mode_e      sel_mode,
    input logic [AW-1:0]   sel_base,
    input logic [AW-1:0]   sel_len
);
    // R4
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (sel != $past(sel)) || (addr_o == $past(ld_val)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !upd) |=> (sel != $past(sel)) || (addr_o == $past(addr_o)));

    // R5
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ld_en && sel_mode == MODE_LIN) |=>
            (sel != $past(sel)) || (addr_o == AW'($past(addr_o) + 1'b1)));

    // R6
    minc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ld_en && !cfg_we && sel_mode == MODE_MINC && (addr_o - sel_base) < sel_len) |=>
            (sel != $past(sel)) || ((addr_o - sel_base) < sel_len));

    // R7
    mdec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ld_en && !cfg_we && sel_mode == MODE_MDEC && (addr_o - sel_base) < sel_len) |=>
            (sel != $past(sel)) || ((addr_o - sel_base) < sel_len));
endmodule

bind agu_top agu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .cfg_we   (cfg_we),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .upd      (upd),
    .addr_o   (addr_o),
    .sel_mode (sel_mode),
    .sel_base (sel_base),
    .sel_len  (sel_len)
);

// File: tb/agu_top_tb.sv
module agu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_len = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = '0;
    logic        upd = 1'b0;
    logic [15:0] addr_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_addr [4];
    logic [15:0] m_base [4];
    logic [15:0] m_len  [4];
    logic [1:0]  m_mode [4];

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    agu_top u_dut (
        .clk (clk), .rst_n (rst_n), .sel (sel), .cfg_we (cfg_we),
        .cfg_mode (cfg_mode), .cfg_base (cfg_base), .cfg_len (cfg_len),
        .ld_en (ld_en), .ld_val (ld_val), .upd (upd), .addr_o (addr_o)
    );

    function automatic logic [15:0] model_step(int r);
        logic [15:0] a, b, n, off, bit_w;
        a = m_addr[r]; b = m_base[r]; n = m_len[r];
        off = a - b;
        case (m_mode[r])
            2'd0: return a + 16'd1;
            2'd1: return (off + 16'd1 >= n) ? b : a + 16'd1;
            2'd2: return (a == b) ? b + n - 16'd1 : a - 16'd1;
            default: begin
                bit_w = n >> 1;
                while (bit_w != 0 && (off & bit_w) != 0) begin
                    off = off ^ bit_w;
                    bit_w = bit_w >> 1;
                end
                off = off | bit_w;
                return b + off;
            end
        endcase
    endfunction

    task automatic op(input int r, input bit c, input logic [1:0] md,
                      input logic [15:0] bs, input logic [15:0] ln,
                      input bit l, input logic [15:0] v, input bit u, input string tag);
        logic [15:0] nxt;
        @(negedge clk);
        sel = 2'(r); cfg_we = c; cfg_mode = md; cfg_base = bs; cfg_len = ln;
        ld_en = l; ld_val = v; upd = u;
        nxt = m_addr[r];
        if (l) nxt = v;
        else if (u) nxt = model_step(r);
        m_addr[r] = nxt;
        if (c) begin m_mode[r] = md; m_base[r] = bs; m_len[r] = ln; end
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    task automatic peek(input int r, input string tag);
        op(r, 0, 2'd0, 16'd0, 16'd0, 0, 16'd0, 0, tag);
    endtask

    task automatic cfg(input int r, input logic [1:0] md, input logic [15:0] bs,
                       input logic [15:0] ln, input string tag);
        op(r, 1, md, bs, ln, 0, 16'd0, 0, tag);
    endtask

    task automatic load(input int r, input logic [15:0] v, input string tag);
        op(r, 0, 2'd0, 16'd0, 16'd0, 1, v, 0, tag);
    endtask

    task automatic step(input int r, input string tag);
        op(r, 0, 2'd0, 16'd0, 16'd0, 0, 16'd0, 1, tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (addr_o !== e) begin
                n_fail++;
                $display("FAIL %s: addr_o=%h expected=%h", t, addr_o, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = 16'h0; m_base[i] = 16'h0; m_len[i] = 16'd1; m_mode[i] = 2'd0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R2 select
        for (int i = 0; i < 4; i++) peek(i, "R1");

        // R3 load, R2 select of each pointer
        load(0, 16'h1234, "R3");
        load(1, 16'h00AA, "R3");
        peek(0, "R2");

        // R5 linear with wrap at 0xFFFF
        load(2, 16'hFFFE, "R3");
        step(2, "R5");
        step(2, "R5");
        step(2, "R5");

        // R9 config leaves address alone
        cfg(1, 2'd1, 16'h0100, 16'd5, "R9");
        load(1, 16'h0102, "R3");
        // R6 circular up, n=5, through the wrap
        for (int k = 0; k < 6; k++) step(1, "R6");

        // R10 neighbours untouched
        peek(0, "R10");
        peek(2, "R10");

        // R7 circular down across base, n=7
        cfg(3, 2'd2, 16'h0200, 16'd7, "R9");
        load(3, 16'h0201, "R3");
        for (int k = 0; k < 4; k++) step(3, "R7");

        // R8 bit-reversed, n=8
        cfg(0, 2'd3, 16'h0300, 16'd8, "R9");
        load(0, 16'h0300, "R3");
        for (int k = 0; k < 9; k++) step(0, "R8");

        // R4 load beats step
        op(1, 0, 2'd0, 16'd0, 16'd0, 1, 16'h0103, 1, "R4");
        step(1, "R6");

        // R9 step in same cycle as config uses old settings
        op(1, 1, 2'd0, 16'h0000, 16'd1, 0, 16'd0, 1, "R9");
        step(1, "R5");

        // R10 idle hold
        peek(1, "R10");
        peek(3, "R10");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule